// File: doc/BRIEF.md
# Power-Fail Access Guard

This block sits between a host bus and a battery-backed memory-plus-clock macro. It watches two digital supply-status flags that analog comparators produce elsewhere. The first says that the main supply is above the level at which writes are still safe. The second says that the supply is above the level at which the macro can run from it rather than from its backup cell. From these flags and the host's chip-enable, write-enable and output-enable strobes (all active low), it produces the internal enable, the internal write strobe, the data-bus driver enable and the battery-select control.

The two directions of a supply transition are timed differently. When the supply sags, the bus keeps working until a short protect delay has run out, and then every access is dropped at once. When the supply comes back, access stays blocked for a much longer recovery period. Both delays count pulses of a microsecond timebase, and the recovery is counted in whole milliseconds built from that timebase. Both the protect delay and the recovery length are parameters. The supply flags pass through a two-flop synchronizer, and all outputs are registered.

Top module: `supply_guard`

## Requirements
- R1: During reset all four outputs are 0, and the block comes out of reset in the protected state. With the supply flag high, no enable appears before a full recovery period has elapsed.
- R2: While access is allowed, mem_en_o is 1 exactly one clock after a cycle with ce_n_i low. dq_oe_o is 1 one clock after a cycle with ce_n_i low, oe_n_i low and we_n_i high.
- R3: mem_we_o is 1 one clock after a cycle with ce_n_i and we_n_i both low. A low we_n_i keeps dq_oe_o at 0, including when ce_n_i and we_n_i fall in the same cycle. The driver enable returns when we_n_i rises while ce_n_i and oe_n_i stay low.
- R4: After the supply flag falls and stays low, all access outputs go to 0 no sooner than PROTECT_US timebase pulses and no later than 5 clocks after the PROTECT_US-th pulse.
- R5: While protected, the strobes are ignored: mem_en_o, mem_we_o and dq_oe_o stay 0 for any strobe pattern.
- R6: A supply dropout that ends before the protect delay runs out causes no deselect and no recovery period.
- R7: After the supply flag returns, access stays blocked for RECOVER_MS × US_PER_MS timebase pulses. The first enable appears within 8 clocks after that if chip enable is toggling.
- R8: A dropout during recovery puts the block back into protection. On the next return, the full recovery period is counted again from zero.
- R9: A write active when protection takes hold ends in the same cycle as mem_en_o. Strobes held low across the whole outage start no access afterwards: ce_n_i must be seen high for one cycle before the next access.
- R10: bat_sel_o is 1 when the switchover flag vbat_ok_i is low and 0 when it is high, three clocks after the flag changes, whatever the access state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us_i | input | 1 | One-clock pulse per microsecond |
| vok_i | input | 1 | Supply above the power-fail threshold |
| vbat_ok_i | input | 1 | Supply above the battery switchover level |
| ce_n_i | input | 1 | Chip enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| mem_en_o | output | 1 | Internal enable to the memory |
| mem_we_o | output | 1 | Internal write strobe |
| dq_oe_o | output | 1 | Data bus driver enable |
| bat_sel_o | output | 1 | Select backup cell as supply |

## Verification
Protection taking hold and an ongoing write strobe can fall in the same clock. The bench holds chip enable and write enable low and then drops the supply flag. At the sample where mem_en_o first reads 0, mem_we_o must also read 0, and one sample earlier the write must still have been live. It then keeps the strobes low through the whole recovery and checks that no access restarts until chip enable has been released for a cycle.

// File: rtl/sg_pkg.sv
package sg_pkg;
  // Access-permission phases of the guard.
  typedef enum logic [1:0] {
    SG_ON      = 2'd0,
    SG_FALLING = 2'd1,
    SG_PROT    = 2'd2,
    SG_RECOV   = 2'd3
  } sg_state_e;
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sg_sequencer.sv
module sg_sequencer
  import sg_pkg::*;
#(
  parameter int PROTECT_US = 100,
  parameter int RECOVER_MS = 100,
  parameter int US_PER_MS  = 1000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      vok_s,
  input  logic      vbat_s,
  output sg_state_e state_o,
  output logic      access_ok_o,
  output logic      bat_sel_o
);
  localparam int PW = (PROTECT_US > 1) ? $clog2(PROTECT_US) : 1;
  localparam int UW = (US_PER_MS  > 1) ? $clog2(US_PER_MS)  : 1;
  localparam int MW = (RECOVER_MS > 1) ? $clog2(RECOVER_MS) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PROTECT_US - 1);
  localparam logic [UW-1:0] ULAST = UW'(US_PER_MS - 1);
  localparam logic [MW-1:0] MLAST = MW'(RECOVER_MS - 1);

  sg_state_e     state;
  logic [PW-1:0] pcnt;
  logic [UW-1:0] ucnt;
  logic [MW-1:0] mcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SG_PROT;
      pcnt  <= '0;
      ucnt  <= '0;
      mcnt  <= '0;
    end else begin
      case (state)
        SG_ON: begin
          if (!vok_s) begin
            state <= SG_FALLING;
            pcnt  <= '0;
          end
        end
        SG_FALLING: begin
          if (vok_s) begin
            state <= SG_ON;
          end else if (tick) begin
            if (pcnt == PLAST) state <= SG_PROT;
            else               pcnt  <= pcnt + PW'(1);
          end
        end
        SG_PROT: begin
          if (vok_s) begin
            state <= SG_RECOV;
            ucnt  <= '0;
            mcnt  <= '0;
          end
        end
        SG_RECOV: begin
          if (!vok_s) begin
            state <= SG_PROT;
          end else if (tick) begin
            if (ucnt == ULAST) begin
              ucnt <= '0;
              if (mcnt == MLAST) state <= SG_ON;
              else               mcnt  <= mcnt + MW'(1);
            end else begin
              ucnt <= ucnt + UW'(1);
            end
          end
        end
        default: state <= SG_PROT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bat_sel_o <= 1'b0;
    else     bat_sel_o <= ~vbat_s;
  end

  assign state_o     = state;
  assign access_ok_o = (state == SG_ON) || (state == SG_FALLING);
endmodule

// File: rtl/sg_gate.sv
module sg_gate (
  input  logic clk,
  input  logic rst,
  input  logic access_ok,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic mem_en,
  output logic mem_we,
  output logic dq_oe
);
  // Re-arm only after chip enable has been seen released while allowed.
  logic armed;
  logic sel;

  always_ff @(posedge clk) begin
    if (rst || !access_ok) armed <= 1'b0;
    else if (ce_n)         armed <= 1'b1;
  end

  assign sel = access_ok && armed && !ce_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      dq_oe  <= 1'b0;
    end else begin
      mem_en <= sel;
      mem_we <= sel && !we_n;
      dq_oe  <= sel && !oe_n && we_n;
    end
  end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import sg_pkg::*;
#(
  parameter int PROTECT_US  = 100,
  parameter int RECOVER_MS  = 100,
  parameter int US_PER_MS   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us_i,
  input  logic vok_i,
  input  logic vbat_ok_i,
  input  logic ce_n_i,
  input  logic we_n_i,
  input  logic oe_n_i,
  output logic mem_en_o,
  output logic mem_we_o,
  output logic dq_oe_o,
  output logic bat_sel_o
);
  logic [1:0] flags_s;
  logic       vok_s;
  logic       vbat_s;
  logic       access_ok;
  sg_state_e  seq_state;

  sg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst(rst), .d({vbat_ok_i, vok_i}), .q(flags_s)
  );
  assign vok_s  = flags_s[0];
  assign vbat_s = flags_s[1];

  sg_sequencer #(
    .PROTECT_US(PROTECT_US), .RECOVER_MS(RECOVER_MS), .US_PER_MS(US_PER_MS)
  ) u_seq (
    .clk(clk), .rst(rst), .tick(tick_us_i), .vok_s(vok_s), .vbat_s(vbat_s),
    .state_o(seq_state), .access_ok_o(access_ok), .bat_sel_o(bat_sel_o)
  );

  sg_gate u_gate (
    .clk(clk), .rst(rst), .access_ok(access_ok),
    .ce_n(ce_n_i), .we_n(we_n_i), .oe_n(oe_n_i),
    .mem_en(mem_en_o), .mem_we(mem_we_o), .dq_oe(dq_oe_o)
  );
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk
  import sg_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      ce_n_i,
  input logic      mem_en_o,
  input logic      mem_we_o,
  input logic      dq_oe_o,
  input sg_state_e state,
  input logic      vok_s,
  input logic      access_ok
);
  assert_we_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_en_o);

  assert_no_drive_in_write_R3: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> (mem_en_o && !mem_we_o));

  assert_en_follows_ce_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_en_o) |-> $past(!ce_n_i));

  assert_blocked_silent_R5: assert property (@(posedge clk) disable iff (rst)
    !access_ok |=> (!mem_en_o && !mem_we_o && !dq_oe_o));

  assert_no_skip_delay_R4: assert property (@(posedge clk) disable iff (rst)
    (state == SG_ON) |=> (state != SG_PROT));

  assert_dip_reprotects_R8: assert property (@(posedge clk) disable iff (rst)
    (state == SG_RECOV && !vok_s) |=> (state == SG_PROT));

  assert_cut_write_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(access_ok) |=> !mem_we_o);
endmodule

bind supply_guard supply_guard_chk u_chk (
  .clk(clk), .rst(rst), .ce_n_i(ce_n_i),
  .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .dq_oe_o(dq_oe_o),
  .state(seq_state), .vok_s(vok_s), .access_ok(access_ok)
);

// File: tb/supply_guard_bench.sv
module supply_guard_bench;
  localparam int P   = 6;
  localparam int U   = 4;
  localparam int RM  = 3;
  localparam int REC = U * RM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b1;
  logic vok = 1'b1, vbat = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic mem_en, mem_we, dq_oe, bat_sel;
  logic slow_tick = 1'b0;
  int   errors = 0, checks = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  supply_guard #(.PROTECT_US(P), .RECOVER_MS(RM), .US_PER_MS(U)) u_supply_guard (
    .clk(clk), .rst(rst), .tick_us_i(tick_us), .vok_i(vok), .vbat_ok_i(vbat),
    .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .dq_oe_o(dq_oe), .bat_sel_o(bat_sel)
  );

  initial begin
    int tc;
    tc = 0;
    forever begin
      @(negedge clk);
      if (slow_tick) begin
        tc = (tc + 1) % 3;
        tick_us = (tc == 0);
      end else begin
        tick_us = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic int exp_en(input logic c);
    return (!c) ? 1 : 0;
  endfunction
  function automatic int exp_we(input logic c, input logic w);
    return (!c && !w) ? 1 : 0;
  endfunction
  function automatic int exp_oe(input logic c, input logic w, input logic o);
    return (!c && w && !o) ? 1 : 0;
  endfunction

  // Toggle chip enable until the first enable appears; returns sample count.
  task automatic measure_access(output int n);
    n = 999;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      if (mem_en === 1'b1) begin n = k; break; end
      ce_n = ~ce_n;
    end
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic measure_deselect(output int n);
    n = 999;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      if (mem_en === 1'b0) begin n = k; break; end
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int n, bad, prev_we;
    logic c, w, o;
    void'($urandom(32'd2718));

    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 reset mem_en", mem_en, 0);
    chk("R1 reset mem_we", mem_we, 0);
    chk("R1 reset dq_oe", dq_oe, 0);
    chk("R1 reset bat_sel", bat_sel, 0);
    rst = 1'b0;
    measure_access(n);
    chk_rng("R1 R7 first access after reset", n, REC, REC + 8);

    // R3: simultaneous fall of chip and write enable
    ce_n = 1; we_n = 1; oe_n = 0;
    @(negedge clk);
    ce_n = 0; we_n = 0;
    @(negedge clk);
    chk("R3 joint fall dq_oe", dq_oe, 0);
    chk("R3 joint fall mem_we", mem_we, 1);
    @(negedge clk);
    chk("R3 held write dq_oe", dq_oe, 0);
    we_n = 1;
    @(negedge clk);
    chk("R3 release we drives", dq_oe, 1);
    we_n = 0;
    @(negedge clk);
    chk("R3 we low cuts drive", dq_oe, 0);
    ce_n = 1; we_n = 1; oe_n = 1;
    @(negedge clk);

    // R2 R3: random strobes while access is allowed
    for (int i = 0; i < 300; i++) begin
      c = ($urandom % 4) == 0;
      w = $urandom % 2;
      o = $urandom % 2;
      ce_n = c; we_n = w; oe_n = o;
      @(negedge clk);
      chk("R2 random mem_en", mem_en, exp_en(c));
      chk("R3 random mem_we", mem_we, exp_we(c, w));
      chk("R2 random dq_oe", dq_oe, exp_oe(c, w, o));
    end

    // R4: deselect delay
    ce_n = 0; we_n = 1; oe_n = 0;
    repeat (2) @(negedge clk);
    chk("R4 read active before drop", dq_oe, 1);
    vok = 0;
    measure_deselect(n);
    chk_rng("R4 deselect delay", n, P, P + 5);
    chk("R4 drive off after deselect", dq_oe, 0);

    // R5: strobes ignored while protected; R10 inside protection
    for (int i = 0; i < 30; i++) begin
      ce_n = $urandom % 2; we_n = $urandom % 2; oe_n = $urandom % 2;
      @(negedge clk);
      chk("R5 protected mem_en", mem_en, 0);
      chk("R5 protected mem_we", mem_we, 0);
      chk("R5 protected dq_oe", dq_oe, 0);
    end
    vbat = 0;
    repeat (2) @(negedge clk);
    chk("R10 bat_sel not early", bat_sel, 0);
    @(negedge clk);
    chk("R10 bat_sel on", bat_sel, 1);
    vbat = 1;
    repeat (3) @(negedge clk);
    chk("R10 bat_sel off", bat_sel, 0);

    // R7: recovery
    ce_n = 1; we_n = 1; oe_n = 1;
    vok = 1;
    measure_access(n);
    chk_rng("R7 recovery length", n, REC, REC + 8);

    // R6: short dropout
    ce_n = 0;
    repeat (2) @(negedge clk);
    vok = 0;
    bad = 0;
    repeat (P - 2) begin @(negedge clk); if (mem_en !== 1'b1) bad++; end
    vok = 1;
    repeat (P + 12) begin @(negedge clk); if (mem_en !== 1'b1) bad++; end
    chk("R6 short dropout ignored", bad, 0);

    // R8: dropout during recovery restarts it
    vok = 0;
    repeat (P + 8) @(negedge clk);
    chk("R8 protected", mem_en, 0);
    vok = 1;
    repeat (11) @(negedge clk);
    vok = 0;
    repeat (3) @(negedge clk);
    ce_n = 1;
    vok = 1;
    measure_access(n);
    chk_rng("R8 full recovery after dip", n, REC, REC + 8);

    // R9: write cut at protection, no resume without ce release
    ce_n = 0; we_n = 0; oe_n = 1;
    repeat (2) @(negedge clk);
    chk("R9 write live", mem_we, 1);
    vok = 0;
    prev_we = 1;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (mem_en === 1'b0) break;
      prev_we = mem_we;
    end
    chk("R9 write until cut", prev_we, 1);
    chk("R9 write cut same cycle", mem_we, 0);
    vok = 1;
    repeat (REC + 15) begin
      @(negedge clk);
      if (mem_en !== 1'b0 || mem_we !== 1'b0) bad++;
    end
    chk("R9 no resume with held strobes", bad, 0);
    ce_n = 1;
    @(negedge clk);
    ce_n = 0;
    @(negedge clk);
    chk("R9 access after ce release", mem_we, 1);

    // R4: delay counts timebase pulses, not clocks
    we_n = 1;
    @(negedge clk);
    slow_tick = 1;
    repeat (3) @(negedge clk);
    vok = 0;
    measure_deselect(n);
    chk_rng("R4 sparse timebase", n, 3 * P - 3, 3 * P + 6);
    slow_tick = 0;
    ce_n = 1;
    vok = 1;
    measure_access(n);
    chk_rng("R7 recovery again", n, REC, REC + 8);

    // R10: battery select while active
    vbat = 0;
    repeat (2) @(negedge clk);
    chk("R10 active not early", bat_sel, 0);
    @(negedge clk);
    chk("R10 active on", bat_sel, 1);
    vbat = 1;
    repeat (2) @(negedge clk);
    chk("R10 active still on", bat_sel, 1);
    @(negedge clk);
    chk("R10 active off", bat_sel, 0);

    done = 1'b1;
    finish_run();
  end
endmodule